// File: doc/BRIEF.md
# Windowed Pixel Moment Accumulator

This block takes a stream of unsigned grey values taken along one line of an image and, for each run of pixels (a window), forms six sums that a later stage uses to fit an ideal step edge at subpixel position. Three of the sums are grey-level moments: the sum of each pixel value raised to the power 1, 2 or 3. The other three are spatial moments: the sum of each pixel value times its distance from the window origin, raised to the power 1, 2 or 3. The block does no division and does not solve for the edge.

Pixels arrive on a valid/ready stream. A start flag travels with the first pixel of each window. That pixel has distance 0, and each later accepted pixel has a distance one higher. The window length comes from an input that is sampled only on the start beat. When the last pixel of a window has been accepted, the six sums appear on an output valid/ready handshake. A one-cycle done pulse marks each newly loaded result. Power terms pass through a two-stage multiplier pipeline, so the latency after the last pixel is fixed. When the output is stalled, the whole pipeline and the input stall with it.

Top module: `pix_moment_acc`

## Requirements
- R1: For a window of N pixels p(0..N-1), out_g1, out_g2 and out_g3 equal the sum of p, the sum of p squared and the sum of p cubed.
- R2: out_s1, out_s2 and out_s3 equal the sum of p(d)*d, p(d)*d^2 and p(d)*d^3. Here d is 0 on the beat that carries in_sof=1 and rises by one for each later accepted beat of the window.
- R3: The window length is taken from win_len only on the in_sof beat, so changes to win_len during a window have no effect. Values below 2 act as 2 and values above MAX_WIN act as MAX_WIN.
- R4: If the last pixel is accepted at clock edge k, out_valid and out_done are high after edge k+2 and not before. out_done is high for exactly one cycle per result.
- R5: An in_sof beat that arrives while a window is still open abandons that window. No result is produced for the abandoned window, and the new window starts at distance 0.
- R6: Accepted beats with in_sof=0 while no window is open are ignored.
- R7: While out_valid=1 and out_ready=0, in_ready is 0 and all six outputs hold their values. Beats offered in that time are not taken.
- R8: While rst_n=0 at a clock edge (synchronous, active low), out_valid and out_done are 0 after that edge and any open window is abandoned. After reset, in_ready is 1.
- R9: No sum overflows. With MAX_WIN pixels all at 2^PIX_W-1, every output matches the exact sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| win_len | input | $clog2(MAX_WIN+1) | Window length, sampled on the start beat |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high together with in_valid |
| in_sof | input | 1 | Marks the first pixel of a window |
| in_pix | input | PIX_W | Unsigned grey value |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed when high together with out_valid |
| out_done | output | 1 | One-cycle pulse when a new result is loaded |
| out_g1 | output | PIX_W+$clog2(MAX_WIN) | Sum of p |
| out_g2 | output | 2*PIX_W+$clog2(MAX_WIN) | Sum of p^2 |
| out_g3 | output | 3*PIX_W+$clog2(MAX_WIN) | Sum of p^3 |
| out_s1 | output | PIX_W+2*$clog2(MAX_WIN) | Sum of p*d |
| out_s2 | output | PIX_W+3*$clog2(MAX_WIN) | Sum of p*d^2 |
| out_s3 | output | PIX_W+4*$clog2(MAX_WIN) | Sum of p*d^3 |

## Verification
The moment sums are tried with five pixel patterns: two-pixel windows, ramps, a dark-to-bright step, pseudo-random values and a full-length window at full scale. Ramps and random values expose errors in the distance weighting and in the product widths. The step shows whether the spatial sums weight the bright side by its real position. The full-scale window at maximum length exposes any accumulator that is too narrow. Directed cases check the following: a length change in mid-window and the clamping of out-of-range lengths; abandonment of a window by an early start; stray beats that carry no start flag; held results under backpressure; and reset in mid-window. In each case a wrong result or an extra result shows up at the output.

// File: rtl/moment_pkg.sv
// moment_pkg: shared widths and types for the windowed moment accumulator.
// Assumes the pixel width and the distance width are small enough that the sums fit in 64 bits.
package moment_pkg;

    // Window tracking state
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

    // Width of the order-n grey power term p^n
    function automatic int gterm_w(int pw, int n);
        return n * pw;
    endfunction

    // Width of the order-n grey sum: term width plus the growth from summing
    function automatic int gsum_w(int pw, int dw, int n);
        return n * pw + dw;
    endfunction

    // Width of the order-n spatial term p*d^n
    function automatic int sterm_w(int pw, int dw, int n);
        return pw + n * dw;
    endfunction

    // Width of the order-n spatial sum
    function automatic int ssum_w(int pw, int dw, int n);
        return pw + (n + 1) * dw;
    endfunction

endpackage

// File: rtl/pix_window_ctl.sv
// pix_window_ctl: tracks window membership of accepted beats and assigns distances.
// Assumes beat = in_valid & in_ready. Produces a tag for each beat that belongs to a window.
// A start beat always opens a new window, abandoning any open window.
module pix_window_ctl
    import moment_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int MAX_WIN = 64,
    parameter int LEN_W   = $clog2(MAX_WIN + 1),
    parameter int DIST_W  = $clog2(MAX_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat,
    input  logic              sof,
    input  logic [PIX_W-1:0]  pix,
    input  logic [LEN_W-1:0]  win_len,
    output logic              tag_vld,
    output logic              tag_first,
    output logic              tag_last,
    output logic [PIX_W-1:0]  tag_pix,
    output logic [DIST_W-1:0] tag_dist
);

    win_state_e        state_q;
    logic [DIST_W-1:0] dist_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  len_eff;

    // Clamp the requested length into the supported range
    always_comb begin
        if (win_len < LEN_W'(2))
            len_eff = LEN_W'(2);
        else if (win_len > LEN_W'(MAX_WIN))
            len_eff = LEN_W'(MAX_WIN);
        else
            len_eff = win_len;
    end

    // Tag the current beat with its window position
    always_comb begin
        tag_pix   = pix;
        tag_vld   = 1'b0;
        tag_first = 1'b0;
        tag_last  = 1'b0;
        tag_dist  = '0;
        if (beat && sof) begin
            tag_vld   = 1'b1;
            tag_first = 1'b1;
        end else if (beat && state_q == WIN_OPEN) begin
            tag_vld  = 1'b1;
            tag_dist = dist_q;
            tag_last = (LEN_W'(dist_q) == len_q - LEN_W'(1));
        end
    end

    // Window state, distance counter and sampled length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_IDLE;
            dist_q  <= '0;
            len_q   <= LEN_W'(2);
        end else if (beat && sof) begin
            state_q <= WIN_OPEN;
            dist_q  <= DIST_W'(1);
            len_q   <= len_eff;
        end else if (beat && state_q == WIN_OPEN) begin
            dist_q <= dist_q + DIST_W'(1);
            if (tag_last)
                state_q <= WIN_IDLE;
        end
    end

endmodule

// File: rtl/pix_power_pipe.sv
// pix_power_pipe: two-stage pipeline that forms the six power terms of a tagged pixel.
// Stage A: p^2, p*d, d^2. Stage B: p^3, p*d^2, p*d^3. Advances only when adv is high.
module pix_power_pipe
    import moment_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int DIST_W = 6,
    localparam int G2T_W = gterm_w(PIX_W, 2),
    localparam int G3T_W = gterm_w(PIX_W, 3),
    localparam int S1T_W = sterm_w(PIX_W, DIST_W, 1),
    localparam int S2T_W = sterm_w(PIX_W, DIST_W, 2),
    localparam int S3T_W = sterm_w(PIX_W, DIST_W, 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              tag_vld,
    input  logic              tag_first,
    input  logic              tag_last,
    input  logic [PIX_W-1:0]  tag_pix,
    input  logic [DIST_W-1:0] tag_dist,
    output logic              t_vld,
    output logic              t_first,
    output logic              t_last,
    output logic [PIX_W-1:0]  t_g1,
    output logic [G2T_W-1:0]  t_g2,
    output logic [G3T_W-1:0]  t_g3,
    output logic [S1T_W-1:0]  t_s1,
    output logic [S2T_W-1:0]  t_s2,
    output logic [S3T_W-1:0]  t_s3
);

    localparam int D2_W = 2 * DIST_W;

    logic              a_vld, a_first, a_last;
    logic [PIX_W-1:0]  a_p;
    logic [DIST_W-1:0] a_d;
    logic [G2T_W-1:0]  a_p2;
    logic [S1T_W-1:0]  a_pd;
    logic [D2_W-1:0]   a_d2;

    // Stage A: square terms and first spatial product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_vld   <= 1'b0;
            a_first <= 1'b0;
            a_last  <= 1'b0;
            a_p     <= '0;
            a_d     <= '0;
            a_p2    <= '0;
            a_pd    <= '0;
            a_d2    <= '0;
        end else if (adv) begin
            a_vld   <= tag_vld;
            a_first <= tag_first;
            a_last  <= tag_last;
            a_p     <= tag_pix;
            a_d     <= tag_dist;
            a_p2    <= G2T_W'(tag_pix) * G2T_W'(tag_pix);
            a_pd    <= S1T_W'(tag_pix) * S1T_W'(tag_dist);
            a_d2    <= D2_W'(tag_dist) * D2_W'(tag_dist);
        end
    end

    // Stage B: cube terms and higher spatial products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_vld   <= 1'b0;
            t_first <= 1'b0;
            t_last  <= 1'b0;
            t_g1    <= '0;
            t_g2    <= '0;
            t_g3    <= '0;
            t_s1    <= '0;
            t_s2    <= '0;
            t_s3    <= '0;
        end else if (adv) begin
            t_vld   <= a_vld;
            t_first <= a_first;
            t_last  <= a_last;
            t_g1    <= a_p;
            t_g2    <= a_p2;
            t_g3    <= G3T_W'(a_p2) * G3T_W'(a_p);
            t_s1    <= a_pd;
            t_s2    <= S2T_W'(a_pd) * S2T_W'(a_d);
            t_s3    <= S3T_W'(a_pd) * S3T_W'(a_d2);
        end
    end

endmodule

// File: rtl/moment_lane.sv
// moment_lane: one running sum with a result register.
// A first-tagged term restarts the sum, which discards any abandoned partial sum.
// A last-tagged term loads the final sum into the result register.
module moment_lane #(
    parameter int TW = 8,
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          t_vld,
    input  logic          t_first,
    input  logic          t_last,
    input  logic [TW-1:0] term,
    output logic [AW-1:0] res
);

    logic [AW-1:0] acc_q;
    logic [AW-1:0] sum_now;

    // Sum including the current term
    always_comb sum_now = (t_first ? '0 : acc_q) + AW'(term);

    // Running sum and final result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            res   <= '0;
        end else if (adv && t_vld) begin
            acc_q <= sum_now;
            if (t_last)
                res <= sum_now;
        end
    end

endmodule

// File: rtl/pix_moment_acc.sv
// pix_moment_acc: windowed grey-level and spatial moment accumulator (orders 1 to 3).
// Assumes the start flag travels with the first pixel of a window. The whole pipeline
// stalls while a result waits on out_ready, so no result is overwritten.
module pix_moment_acc
    import moment_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int MAX_WIN = 64,
    localparam int LEN_W  = $clog2(MAX_WIN + 1),
    localparam int DIST_W = $clog2(MAX_WIN),
    localparam int G1_W   = gsum_w(PIX_W, DIST_W, 1),
    localparam int G2_W   = gsum_w(PIX_W, DIST_W, 2),
    localparam int G3_W   = gsum_w(PIX_W, DIST_W, 3),
    localparam int S1_W   = ssum_w(PIX_W, DIST_W, 1),
    localparam int S2_W   = ssum_w(PIX_W, DIST_W, 2),
    localparam int S3_W   = ssum_w(PIX_W, DIST_W, 3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] win_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_done,
    output logic [G1_W-1:0]  out_g1,
    output logic [G2_W-1:0]  out_g2,
    output logic [G3_W-1:0]  out_g3,
    output logic [S1_W-1:0]  out_s1,
    output logic [S2_W-1:0]  out_s2,
    output logic [S3_W-1:0]  out_s3
);

    localparam int G2T_W = gterm_w(PIX_W, 2);
    localparam int G3T_W = gterm_w(PIX_W, 3);
    localparam int S1T_W = sterm_w(PIX_W, DIST_W, 1);
    localparam int S2T_W = sterm_w(PIX_W, DIST_W, 2);
    localparam int S3T_W = sterm_w(PIX_W, DIST_W, 3);

    logic              adv;
    logic              beat;
    logic              tag_vld, tag_first, tag_last;
    logic [PIX_W-1:0]  tag_pix;
    logic [DIST_W-1:0] tag_dist;
    logic              t_vld, t_first, t_last;
    logic [PIX_W-1:0]  t_g1;
    logic [G2T_W-1:0]  t_g2;
    logic [G3T_W-1:0]  t_g3;
    logic [S1T_W-1:0]  t_s1;
    logic [S2T_W-1:0]  t_s2;
    logic [S3T_W-1:0]  t_s3;
    logic              vld_q, done_q;
    logic              load;

    // Pipeline moves unless a result is held by the consumer
    always_comb begin
        adv  = !vld_q || out_ready;
        beat = in_valid && adv;
        load = adv && t_vld && t_last;
    end

    assign in_ready  = adv;
    assign out_valid = vld_q;
    assign out_done  = done_q;

    pix_window_ctl #(
        .PIX_W(PIX_W), .MAX_WIN(MAX_WIN), .LEN_W(LEN_W), .DIST_W(DIST_W)
    ) i_ctl (
        .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof), .pix(in_pix),
        .win_len(win_len), .tag_vld(tag_vld), .tag_first(tag_first),
        .tag_last(tag_last), .tag_pix(tag_pix), .tag_dist(tag_dist)
    );

    pix_power_pipe #(
        .PIX_W(PIX_W), .DIST_W(DIST_W)
    ) i_pipe (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .tag_vld(tag_vld), .tag_first(tag_first), .tag_last(tag_last),
        .tag_pix(tag_pix), .tag_dist(tag_dist),
        .t_vld(t_vld), .t_first(t_first), .t_last(t_last),
        .t_g1(t_g1), .t_g2(t_g2), .t_g3(t_g3),
        .t_s1(t_s1), .t_s2(t_s2), .t_s3(t_s3)
    );

    moment_lane #(.TW(PIX_W), .AW(G1_W)) i_lane_g1 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .t_vld(t_vld), .t_first(t_first),
        .t_last(t_last), .term(t_g1), .res(out_g1));
    moment_lane #(.TW(G2T_W), .AW(G2_W)) i_lane_g2 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .t_vld(t_vld), .t_first(t_first),
        .t_last(t_last), .term(t_g2), .res(out_g2));
    moment_lane #(.TW(G3T_W), .AW(G3_W)) i_lane_g3 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .t_vld(t_vld), .t_first(t_first),
        .t_last(t_last), .term(t_g3), .res(out_g3));
    moment_lane #(.TW(S1T_W), .AW(S1_W)) i_lane_s1 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .t_vld(t_vld), .t_first(t_first),
        .t_last(t_last), .term(t_s1), .res(out_s1));
    moment_lane #(.TW(S2T_W), .AW(S2_W)) i_lane_s2 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .t_vld(t_vld), .t_first(t_first),
        .t_last(t_last), .term(t_s2), .res(out_s2));
    moment_lane #(.TW(S3T_W), .AW(S3_W)) i_lane_s3 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .t_vld(t_vld), .t_first(t_first),
        .t_last(t_last), .term(t_s3), .res(out_s3));

    // Result valid flag and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= load;
            if (load)
                vld_q <= 1'b1;
            else if (out_ready)
                vld_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pix_moment_acc_chk.sv
// pix_moment_acc_chk: protocol and range properties of the moment accumulator ports.
module pix_moment_acc_chk
    import moment_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int MAX_WIN = 64,
    localparam int LEN_W  = $clog2(MAX_WIN + 1),
    localparam int DIST_W = $clog2(MAX_WIN),
    localparam int G1_W   = gsum_w(PIX_W, DIST_W, 1),
    localparam int G2_W   = gsum_w(PIX_W, DIST_W, 2),
    localparam int G3_W   = gsum_w(PIX_W, DIST_W, 3),
    localparam int S1_W   = ssum_w(PIX_W, DIST_W, 1),
    localparam int S2_W   = ssum_w(PIX_W, DIST_W, 2),
    localparam int S3_W   = ssum_w(PIX_W, DIST_W, 3)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_done,
    input logic [G1_W-1:0]  out_g1,
    input logic [G2_W-1:0]  out_g2,
    input logic [G3_W-1:0]  out_g3,
    input logic [S1_W-1:0]  out_s1,
    input logic [S2_W-1:0]  out_s2,
    input logic [S3_W-1:0]  out_s3
);

    localparam longint G1_MAX = longint'(MAX_WIN) * ((longint'(1) << PIX_W) - 1);

    // R7
    held_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_g1) && $stable(out_g3)
                                    && $stable(out_s1) && $stable(out_s3));

    // R7
    input_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R4
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_valid);

    // R4
    rise_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_done);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !out_done);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> longint'(out_g1) <= G1_MAX);

    // R1
    grey_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (G3_W'(out_g2) <= out_g3) && (G2_W'(out_g1) <= out_g2));

    // R2
    spatial_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (S3_W'(out_s2) <= out_s3) && (S2_W'(out_s1) <= out_s2));

endmodule

bind pix_moment_acc pix_moment_acc_chk #(.PIX_W(PIX_W), .MAX_WIN(MAX_WIN)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_done(out_done), .out_g1(out_g1), .out_g2(out_g2),
    .out_g3(out_g3), .out_s1(out_s1), .out_s2(out_s2), .out_s3(out_s3)
);

// File: tb/test_pix_moment_acc.sv
// test_pix_moment_acc: vector table of windows followed by directed corner cases.
module test_pix_moment_acc;

    localparam int PIX_W   = 8;
    localparam int MAX_WIN = 64;
    localparam int LEN_W   = $clog2(MAX_WIN + 1);
    localparam int DIST_W  = $clog2(MAX_WIN);
    localparam int PMASK   = (1 << PIX_W) - 1;

    // {win_len, pattern kind, pattern parameter}
    localparam int NVEC = 7;
    localparam int VTAB [0:NVEC-1][0:2] = '{
        '{2, 1, 7},
        '{8, 2, 3},
        '{16, 3, 11},
        '{64, 0, 255},
        '{33, 1, 5},
        '{64, 3, 99},
        '{12, 2, 9}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LEN_W-1:0] win_len = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             in_sof = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic             out_done;
    logic [PIX_W+DIST_W-1:0]   out_g1;
    logic [2*PIX_W+DIST_W-1:0] out_g2;
    logic [3*PIX_W+DIST_W-1:0] out_g3;
    logic [PIX_W+2*DIST_W-1:0] out_s1;
    logic [PIX_W+3*DIST_W-1:0] out_s2;
    logic [PIX_W+4*DIST_W-1:0] out_s3;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pix_moment_acc #(.PIX_W(PIX_W), .MAX_WIN(MAX_WIN)) i_pix_moment_acc (
        .clk(clk), .rst_n(rst_n), .win_len(win_len), .in_valid(in_valid),
        .in_ready(in_ready), .in_sof(in_sof), .in_pix(in_pix),
        .out_valid(out_valid), .out_ready(out_ready), .out_done(out_done),
        .out_g1(out_g1), .out_g2(out_g2), .out_g3(out_g3),
        .out_s1(out_s1), .out_s2(out_s2), .out_s3(out_s3)
    );

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic int pix_at(int kind, int prm, int i);
        case (kind)
            0: return prm & PMASK;
            1: return (i * prm) & PMASK;
            2: return (i < prm) ? 20 : 230;
            default: return ((i * 1103 + prm) * 75 + 74) % 256;
        endcase
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Compare the six outputs with sums formed from the requirement formulas
    task automatic check_res(string req, int kind, int prm, int n);
        longint e [6];
        for (int k = 0; k < 6; k++) e[k] = 0;
        for (int i = 0; i < n; i++) begin
            longint p = longint'(pix_at(kind, prm, i));
            longint d = longint'(i);
            e[0] += p;
            e[1] += p * p;
            e[2] += p * p * p;
            e[3] += p * d;
            e[4] += p * d * d;
            e[5] += p * d * d * d;
        end
        chk({req, " g1"}, longint'(out_g1), e[0]);
        chk({req, " g2"}, longint'(out_g2), e[1]);
        chk({req, " g3"}, longint'(out_g3), e[2]);
        chk({req, " s1"}, longint'(out_s1), e[3]);
        chk({req, " s2"}, longint'(out_s2), e[4]);
        chk({req, " s3"}, longint'(out_s3), e[5]);
    endtask

    // Drive n beats; first carries the start flag and len0, the rest see len_rest
    task automatic send_win(int len0, int len_rest, int n, int kind, int prm, bit with_sof);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = with_sof && (i == 0);
            in_pix   = PIX_W'(pix_at(kind, prm, i));
            win_len  = LEN_W'((i == 0) ? len0 : len_rest);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic wait_valid();
        for (int t = 0; t < 20 && !out_valid; t++) @(negedge clk);
    endtask

    task automatic consume();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 reset valid", longint'(out_valid), 0);
        chk("R8 reset ready", longint'(in_ready), 1);
        rst_n = 1'b1;

        // R1 R2 R9 vector table
        for (int v = 0; v < NVEC; v++) begin
            send_win(VTAB[v][0], VTAB[v][0], VTAB[v][0], VTAB[v][1], VTAB[v][2], 1'b1);
            wait_valid();
            chk("R1 valid", longint'(out_valid), 1);
            check_res((VTAB[v][0] == 64 && VTAB[v][1] == 0) ? "R9" : "R1/R2",
                      VTAB[v][1], VTAB[v][2], VTAB[v][0]);
            consume();
        end

        // R4 latency and done pulse
        send_win(5, 5, 5, 3, 4, 1'b1);
        chk("R4 valid at k", longint'(out_valid), 0);
        @(negedge clk);
        chk("R4 valid at k+1", longint'(out_valid), 0);
        @(negedge clk);
        chk("R4 valid at k+2", longint'(out_valid), 1);
        chk("R4 done at k+2", longint'(out_done), 1);
        @(negedge clk);
        chk("R4 done single", longint'(out_done), 0);
        check_res("R4", 3, 4, 5);
        consume();

        // R3 length change mid-window ignored
        send_win(5, 20, 5, 1, 9, 1'b1);
        wait_valid();
        chk("R3 sampled len", longint'(out_valid), 1);
        check_res("R3 sampled", 1, 9, 5);
        consume();
        // R3 clamp low (1 and 0 act as 2)
        send_win(1, 1, 2, 3, 5, 1'b1);
        wait_valid();
        check_res("R3 clamp1", 3, 5, 2);
        consume();
        send_win(0, 0, 2, 1, 40, 1'b1);
        wait_valid();
        check_res("R3 clamp0", 1, 40, 2);
        consume();
        // R3 clamp high (100 acts as 64)
        send_win(100, 100, 64, 3, 7, 1'b1);
        wait_valid();
        check_res("R3 clamp high", 3, 7, 64);
        consume();

        // R5 early start abandons window
        send_win(8, 8, 3, 0, 200, 1'b1);
        repeat (4) @(negedge clk);
        chk("R5 no result", longint'(out_valid), 0);
        send_win(4, 4, 4, 2, 2, 1'b1);
        wait_valid();
        check_res("R5 new window", 2, 2, 4);
        consume();
        // R5 back-to-back: start flag on the beat after a partial window
        send_win(10, 10, 6, 3, 1, 1'b1);
        send_win(3, 3, 3, 1, 33, 1'b1);
        wait_valid();
        check_res("R5 back-to-back", 1, 33, 3);
        consume();

        // R6 stray beats without start are ignored
        send_win(3, 3, 6, 0, 99, 1'b0);
        repeat (4) @(negedge clk);
        chk("R6 no result", longint'(out_valid), 0);
        send_win(6, 6, 6, 1, 3, 1'b1);
        wait_valid();
        check_res("R6 after stray", 1, 3, 6);

        // R7 backpressure: hold result, offer a start beat that must not be taken
        for (int t = 0; t < 5; t++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = 1'b1;
            in_pix   = 8'd77;
            win_len  = LEN_W'(3);
            chk("R7 ready low", longint'(in_ready), 0);
            chk("R7 valid held", longint'(out_valid), 1);
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        check_res("R7 held data", 1, 3, 6);
        consume();
        chk("R7 consumed", longint'(out_valid), 0);
        send_win(3, 3, 2, 0, 5, 1'b0);
        repeat (4) @(negedge clk);
        chk("R7 offered beat not taken", longint'(out_valid), 0);

        // R8 reset in mid-window
        send_win(10, 10, 4, 0, 250, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mid reset valid", longint'(out_valid), 0);
        rst_n = 1'b1;
        chk("R8 mid reset ready", longint'(in_ready), 1);
        send_win(10, 10, 6, 0, 250, 1'b0);
        repeat (4) @(negedge clk);
        chk("R8 window abandoned", longint'(out_valid), 0);
        send_win(4, 4, 4, 1, 17, 1'b1);
        wait_valid();
        check_res("R8 after reset", 1, 17, 4);
        consume();

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule